// File: doc/BRIEF.md
# Vector Float Truncate-to-Int32-Range Unit

This block takes a packed vector of IEEE-754 floating-point lanes and rounds every lane toward zero to a whole number, keeping the result in the lane's own floating-point format. Each result must also fit a signed 32-bit integer. A lane that is infinite, NaN or too large in magnitude is replaced by the floating-point encoding of -2^31, and the invalid flag is raised. A lane that loses a nonzero fraction raises the inexact flag.

Two select inputs set the layout. One picks single or double precision lanes and the other picks a 64-bit or 128-bit vector. Single precision with a double-wide lane count in a narrow vector is not possible, and double precision in a 64-bit vector is reported as an undefined encoding. The unit has one register stage: inputs presented before a clock edge produce results and flags after that edge.

Top module: `fr32z_vec_round`

## Requirements
- R1: All outputs are registered. A value driven before a rising edge appears at the outputs after that edge and holds until the next edge. While `rst_n` is low at a rising edge, every output is cleared to zero.
- R2: With `prec_dbl`=0, lanes are 32-bit single precision and lane i occupies bits [32i+31:32i]. With `prec_dbl`=1, lanes are 64-bit double precision and lane i occupies bits [64i+63:64i]. With `vec_wide`=1 the vector is 128 bits; with `vec_wide`=0 it is 64 bits.
- R3: A finite lane whose truncated value lies within the signed 32-bit range is rounded toward zero. For example, 2.75 gives 2.0 and -2.75 gives -2.0. A lane that is already integral passes through unchanged and raises no flag.
- R4: A zero lane of either sign returns the same signed zero and raises no flag.
- R5: A nonzero lane with magnitude below 1, subnormals included, returns a zero carrying the input's sign and raises inexact.
- R6: An infinite or NaN lane returns -2^31 in its lane format (0xCF000000 single, 0xC1E0000000000000 double) and raises invalid. Such a lane by itself does not raise inexact.
- R7: A lane is out of range when its truncated value exceeds 2^31-1 or is below -2^31. Such a lane is handled as in R6. Exactly -2^31 is valid and exact. In double precision, -2^31-0.5 truncates to -2^31 and raises inexact only, while -2^31-1 and 2^31 are invalid.
- R8: `flag_inexact` and `flag_invalid` are each the OR over the active lanes only. Lanes in the upper 64 bits are inactive when `vec_wide`=0.
- R9: When `vec_wide`=0, result bits [127:64] are zero.
- R10: When `prec_dbl`=1 and `vec_wide`=0, `undef_enc` is 1, the result is all zero and both flags are 0. For every other combination, `undef_enc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd | input | 128 | Packed operand vector |
| prec_dbl | input | 1 | 0: single precision lanes, 1: double precision lanes |
| vec_wide | input | 1 | 0: 64-bit vector, 1: 128-bit vector |
| res | output | 128 | Packed result vector |
| undef_enc | output | 1 | Undefined precision/width combination |
| flag_inexact | output | 1 | Some active lane lost a nonzero fraction |
| flag_invalid | output | 1 | Some active lane was infinite, NaN or out of range |

## Verification
The hardest case to reach is the narrow band just beyond -2^31 in double precision. There, the exponent equals the limit, and only the bits kept after truncation decide between a valid inexact lane and an invalid one. The stimulus places -2^31-0.5 and -2^31-1 side by side in one double vector, so that a single wrong mask boundary shows up in the result bits and in the flags. A second hard case is the narrow vector mode with NaNs in the inactive upper lanes. This mode shows that those lanes reach neither the result nor the flags.

// File: rtl/fr32z_pkg.sv
// Package: shared format constants for the truncate-to-int32-range unit.
// Assumes IEEE-754 binary32 and binary64 layouts.
package fr32z_pkg;
    localparam int SP_EW = 8;     // single exponent width
    localparam int SP_MW = 23;    // single fraction width
    localparam int DP_EW = 11;    // double exponent width
    localparam int DP_MW = 52;    // double fraction width
    localparam int SP_W  = 1 + SP_EW + SP_MW;
    localparam int DP_W  = 1 + DP_EW + DP_MW;
endpackage

// File: rtl/fr32z_lane.sv
// Module: one lane of round-toward-zero with a signed integer range limit.
// Parameterised over exponent and fraction widths so the same logic
// serves single and double precision. Purely combinational.
// Assumes INT_BITS-1 + bias fits in the exponent field.
module fr32z_lane #(
    parameter int EW       = 8,
    parameter int MW       = 23,
    parameter int INT_BITS = 32
) (
    input  logic [EW+MW:0] opnd,
    output logic [EW+MW:0] res,
    output logic           inexact,
    output logic           invalid
);
    localparam int W    = 1 + EW + MW;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam logic [EW-1:0] EXP_ONE = EW'(BIAS);
    localparam logic [EW-1:0] EXP_TOP = EW'(BIAS + INT_BITS - 1);
    localparam logic [EW-1:0] EXP_MAX = '1;

    logic          sgn;
    logic [EW-1:0] ex;
    logic [MW-1:0] fr;
    logic [EW-1:0] sh;
    logic [MW-1:0] drop_mask;
    logic [MW-1:0] kept;

    assign {sgn, ex, fr} = opnd;

    // Build the mask of fraction bits that sit below the binary point.
    always_comb begin
        sh        = ex - EXP_ONE;
        drop_mask = {MW{1'b1}} >> sh;
        kept      = fr & ~drop_mask;
    end

    // Classify the lane and form the truncated result and its flags.
    always_comb begin
        res     = opnd;
        inexact = 1'b0;
        invalid = 1'b0;
        if (ex == EXP_MAX) begin
            invalid = 1'b1;                       // infinity or NaN
        end else if (ex > EXP_TOP) begin
            invalid = 1'b1;                       // magnitude >= 2^INT_BITS
        end else if (ex < EXP_ONE) begin
            res     = {sgn, {(W-1){1'b0}}};
            inexact = (ex != '0) || (fr != '0);
        end else if ((ex == EXP_TOP) && (!sgn || (kept != '0))) begin
            invalid = 1'b1;                       // beyond the signed limit
        end else begin
            res     = {sgn, ex, kept};
            inexact = |(fr & drop_mask);
        end
        if (invalid) begin
            res = {1'b1, EXP_TOP, {MW{1'b0}}};
        end
    end
endmodule

// File: rtl/fr32z_select.sv
// Module: picks single or double lane results by mode, zeroes inactive
// lanes, and ORs the flags of active lanes. Combinational.
// Assumes VEC_W is a multiple of 128 bits' lane layout (two halves).
module fr32z_select
    import fr32z_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]       sp_res,
    input  logic [VEC_W/SP_W-1:0]  sp_inx,
    input  logic [VEC_W/SP_W-1:0]  sp_inv,
    input  logic [VEC_W-1:0]       dp_res,
    input  logic [VEC_W/DP_W-1:0]  dp_inx,
    input  logic [VEC_W/DP_W-1:0]  dp_inv,
    input  logic                   prec_dbl,
    input  logic                   vec_wide,
    output logic [VEC_W-1:0]       res,
    output logic                   undef_enc,
    output logic                   inexact,
    output logic                   invalid
);
    localparam int SP_N = VEC_W / SP_W;
    localparam int DP_N = VEC_W / DP_W;

    logic [SP_N-1:0]  sp_act;
    logic [DP_N-1:0]  dp_act;
    logic [VEC_W-1:0] sp_kept;
    logic [VEC_W-1:0] dp_kept;

    // An undefined combination blocks every lane.
    assign undef_enc = prec_dbl & ~vec_wide;

    genvar gi;
    generate
        for (gi = 0; gi < SP_N; gi++) begin : g_sp
            // Single lanes in the lower half are always live.
            assign sp_act[gi] = vec_wide || (gi < SP_N / 2);
            assign sp_kept[gi*SP_W +: SP_W] =
                sp_act[gi] ? sp_res[gi*SP_W +: SP_W] : '0;
        end
        for (gi = 0; gi < DP_N; gi++) begin : g_dp
            // Double lanes exist only in the wide vector.
            assign dp_act[gi] = vec_wide;
            assign dp_kept[gi*DP_W +: DP_W] =
                dp_act[gi] ? dp_res[gi*DP_W +: DP_W] : '0;
        end
    endgenerate

    // Route the chosen precision and reduce its flags.
    always_comb begin
        if (undef_enc) begin
            res     = '0;
            inexact = 1'b0;
            invalid = 1'b0;
        end else if (prec_dbl) begin
            res     = dp_kept;
            inexact = |(dp_inx & dp_act);
            invalid = |(dp_inv & dp_act);
        end else begin
            res     = sp_kept;
            inexact = |(sp_inx & sp_act);
            invalid = |(sp_inv & sp_act);
        end
    end
endmodule

// File: rtl/fr32z_vec_round.sv
// Module: top of the vector truncate-to-int32-range unit. Runs single
// and double lane units side by side, selects by mode, registers once.
// Assumes operands are held stable around the sampling edge.
module fr32z_vec_round
    import fr32z_pkg::*;
#(
    parameter int VEC_W    = 128,
    parameter int INT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] opnd,
    input  logic             prec_dbl,
    input  logic             vec_wide,
    output logic [VEC_W-1:0] res,
    output logic             undef_enc,
    output logic             flag_inexact,
    output logic             flag_invalid
);
    localparam int SP_N = VEC_W / SP_W;
    localparam int DP_N = VEC_W / DP_W;

    logic [VEC_W-1:0] sp_res, dp_res, sel_res;
    logic [SP_N-1:0]  sp_inx, sp_inv;
    logic [DP_N-1:0]  dp_inx, dp_inv;
    logic             sel_undef, sel_inx, sel_inv;

    genvar gi;
    generate
        for (gi = 0; gi < SP_N; gi++) begin : g_sp_lane
            fr32z_lane #(.EW(SP_EW), .MW(SP_MW), .INT_BITS(INT_BITS)) u_lane (
                .opnd    (opnd[gi*SP_W +: SP_W]),
                .res     (sp_res[gi*SP_W +: SP_W]),
                .inexact (sp_inx[gi]),
                .invalid (sp_inv[gi])
            );
        end
        for (gi = 0; gi < DP_N; gi++) begin : g_dp_lane
            fr32z_lane #(.EW(DP_EW), .MW(DP_MW), .INT_BITS(INT_BITS)) u_lane (
                .opnd    (opnd[gi*DP_W +: DP_W]),
                .res     (dp_res[gi*DP_W +: DP_W]),
                .inexact (dp_inx[gi]),
                .invalid (dp_inv[gi])
            );
        end
    endgenerate

    fr32z_select #(.VEC_W(VEC_W)) u_select (
        .sp_res    (sp_res),
        .sp_inx    (sp_inx),
        .sp_inv    (sp_inv),
        .dp_res    (dp_res),
        .dp_inx    (dp_inx),
        .dp_inv    (dp_inv),
        .prec_dbl  (prec_dbl),
        .vec_wide  (vec_wide),
        .res       (sel_res),
        .undef_enc (sel_undef),
        .inexact   (sel_inx),
        .invalid   (sel_inv)
    );

    // Output register stage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res          <= '0;
            undef_enc    <= 1'b0;
            flag_inexact <= 1'b0;
            flag_invalid <= 1'b0;
        end else begin
            res          <= sel_res;
            undef_enc    <= sel_undef;
            flag_inexact <= sel_inx;
            flag_invalid <= sel_inv;
        end
    end
endmodule

// File: rtl/fr32z_vec_round_chk.sv
// Module: property checker for the vector truncate unit, bound to the top.
// Assumes the default 128-bit vector and 32-bit integer limit.
module fr32z_vec_round_chk (
    input logic         clk,
    input logic         rst_n,
    input logic [127:0] opnd,
    input logic         prec_dbl,
    input logic         vec_wide,
    input logic [127:0] res,
    input logic         undef_enc,
    input logic         flag_inexact,
    input logic         flag_invalid
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (res == '0 && !undef_enc && !flag_inexact && !flag_invalid));

    // R10
    undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prec_dbl && !vec_wide) |=> (undef_enc && res == '0 && !flag_inexact && !flag_invalid));

    // R10
    legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prec_dbl && !vec_wide) |=> !undef_enc);

    // R9
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_wide |=> (res[127:64] == '0));

    // R6
    sp_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prec_dbl && opnd[30:23] == 8'hFF) |=> (flag_invalid && res[31:0] == 32'hCF000000));

    // R6
    dp_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prec_dbl && vec_wide && opnd[62:52] == 11'h7FF)
        |=> (flag_invalid && res[63:0] == 64'hC1E0000000000000));

    // R4
    sp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prec_dbl && opnd[30:0] == '0) |=> (res[31:0] == $past(opnd[31:0])));
endmodule

bind fr32z_vec_round fr32z_vec_round_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .opnd         (opnd),
    .prec_dbl     (prec_dbl),
    .vec_wide     (vec_wide),
    .res          (res),
    .undef_enc    (undef_enc),
    .flag_inexact (flag_inexact),
    .flag_invalid (flag_invalid)
);

// File: tb/test_fr32z_vec_round.sv
// Directed bench for the vector truncate-to-int32-range unit.
module test_fr32z_vec_round;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] opnd = '0;
    logic         prec_dbl = 1'b0;
    logic         vec_wide = 1'b1;
    logic [127:0] res;
    logic         undef_enc, flag_inexact, flag_invalid;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    fr32z_vec_round i_fr32z_vec_round (
        .clk          (clk),
        .rst_n        (rst_n),
        .opnd         (opnd),
        .prec_dbl     (prec_dbl),
        .vec_wide     (vec_wide),
        .res          (res),
        .undef_enc    (undef_enc),
        .flag_inexact (flag_inexact),
        .flag_invalid (flag_invalid)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; results are registered at the next rising edge.
    task automatic apply(input logic d, input logic w, input logic [127:0] v);
        @(negedge clk);
        prec_dbl = d;
        vec_wide = w;
        opnd     = v;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [127:0] r,
                              input logic u, input logic inx, input logic inv);
        check({req, " result"}, res, r);
        check({req, " undef"}, {127'b0, undef_enc}, {127'b0, u});
        check({req, " inexact"}, {127'b0, flag_inexact}, {127'b0, inx});
        check({req, " invalid"}, {127'b0, flag_invalid}, {127'b0, inv});
    endtask

    task automatic t_reset;
        repeat (2) @(negedge clk);
        expect_out("R1 reset", '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;
        apply(1'b0, 1'b1, {32'h42C80000, 32'h42C80000, 32'h42C80000, 32'h3F800000});
        @(negedge clk);
        opnd = {96'h0, 32'h40000000};
        #2;
        check("R1 hold before edge", res, {32'h42C80000, 32'h42C80000, 32'h42C80000, 32'h3F800000});
        @(negedge clk);
        check("R1 update after edge", res, {96'h0, 32'h40000000});
        rst_n = 1'b0;
        @(negedge clk);
        expect_out("R1 mid-run reset", '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_single_trunc;
        apply(1'b0, 1'b1, {32'h42C80000, 32'hC0300000, 32'h3FC00000, 32'h40300000});
        expect_out("R2 R3 single trunc",
                   {32'h42C80000, 32'hC0000000, 32'h3F800000, 32'h40000000}, 1'b0, 1'b1, 1'b0);
        apply(1'b0, 1'b1, {32'h42C80000, 32'h4EFFFFFF, 32'hCF000000, 32'h3F800000});
        expect_out("R3 R7 single exact",
                   {32'h42C80000, 32'h4EFFFFFF, 32'hCF000000, 32'h3F800000}, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_zero_small;
        apply(1'b0, 1'b1, {32'h80000000, 32'h00000000, 32'h80000000, 32'h00000000});
        expect_out("R4 signed zero",
                   {32'h80000000, 32'h00000000, 32'h80000000, 32'h00000000}, 1'b0, 1'b0, 1'b0);
        apply(1'b0, 1'b1, {32'hBF000000, 32'h3F000000, 32'h00000001, 32'h80000001});
        expect_out("R5 below one",
                   {32'h80000000, 32'h00000000, 32'h00000000, 32'h80000000}, 1'b0, 1'b1, 1'b0);
        apply(1'b1, 1'b1, {64'hBFD0000000000000, 64'h0000000000000001});
        expect_out("R5 double below one",
                   {64'h8000000000000000, 64'h0}, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_single_invalid;
        apply(1'b0, 1'b1, {32'h7FC00000, 32'h7F800000, 32'hFF800000, 32'h4F000000});
        expect_out("R6 R7 single invalid",
                   {4{32'hCF000000}}, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_double;
        apply(1'b1, 1'b1, {64'hC006000000000000, 64'h4006000000000000});
        expect_out("R2 R3 double trunc",
                   {64'hC000000000000000, 64'h4000000000000000}, 1'b0, 1'b1, 1'b0);
        apply(1'b1, 1'b1, {64'h41DFFFFFFFC00000, 64'hC1E0000000100000});
        expect_out("R7 double near limit valid",
                   {64'h41DFFFFFFFC00000, 64'hC1E0000000000000}, 1'b0, 1'b1, 1'b0);
        apply(1'b1, 1'b1, {64'h41E0000000000000, 64'hC1E0000000200000});
        expect_out("R7 double beyond limit",
                   {2{64'hC1E0000000000000}}, 1'b0, 1'b0, 1'b1);
        apply(1'b1, 1'b1, {64'h3FF0000000000000, 64'h7FF8000000000000});
        expect_out("R6 double NaN",
                   {64'h3FF0000000000000, 64'hC1E0000000000000}, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_flag_or;
        apply(1'b1, 1'b1, {64'h3FF8000000000000, 64'h7FF0000000000000});
        expect_out("R8 mixed lane flags",
                   {64'h3FF0000000000000, 64'hC1E0000000000000}, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_narrow;
        apply(1'b0, 1'b0, {32'h7F800000, 32'h40300000, 32'h3F800000, 32'h42C80000});
        expect_out("R8 R9 narrow upper ignored",
                   {64'h0, 32'h3F800000, 32'h42C80000}, 1'b0, 1'b0, 1'b0);
        apply(1'b0, 1'b0, {64'hFFFFFFFF_FFFFFFFF, 32'h3FC00000, 32'h7F800000});
        expect_out("R8 R9 narrow lower flags",
                   {64'h0, 32'h3F800000, 32'hCF000000}, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_undef;
        apply(1'b1, 1'b0, {64'h7FF0000000000000, 64'h4006000000000000});
        expect_out("R10 undefined combo", '0, 1'b1, 1'b0, 1'b0);
        apply(1'b1, 1'b1, {64'h4006000000000000, 64'h3FF0000000000000});
        expect_out("R10 legal after undefined",
                   {64'h4000000000000000, 64'h3FF0000000000000}, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_single_trunc();
        t_zero_small();
        t_single_invalid();
        t_double();
        t_flag_or();
        t_narrow();
        t_undef();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule